// File: doc/BRIEF.md
# Far Line Cache Controller

This controller sits between a node's local processor bus and the ring that joins the nodes of a shared-memory cluster. Every line address carries the number of its home node in its top bits. When a local request names this node, it goes straight to local memory. When it names another node, it is looked up in a small set-associative cache that holds copies of remote lines. A hit completes locally and causes no ring traffic. A miss sends a read request to the line's home node and holds the local bus until the fill arrives.

The cache is normally full. Each fill therefore evicts a line chosen by a per-set tree pseudo-LRU. Every valid victim produces a rollout request on the ring, clean or dirty, and the rollout carries the victim's dirty flag.

Requests arriving from other nodes are handled alongside local lookups. Reads, writes and tag updates for lines homed here go to the local memory port. Tag updates for remote lines invalidate the cached copy. If a tag update names the line whose fill is still outstanding, it is held back and applied once the line has been installed.

Top module: `fmc_ctrl`

## Requirements
- R1: A request is local when its top NODE_W address bits equal MY_NODE. One cycle after acceptance the block gives lrsp_valid with lrsp_far=0 and lrsp_hit=0, and it raises no ring request.
- R2: A far request whose line is cached and valid gets, one cycle after acceptance, lrsp_valid with lrsp_far=1 and lrsp_hit=1, and no ring request.
- R3: A far miss raises ring_req_valid one cycle after acceptance. The request carries ring_req_op=1 (line read), ring_req_node set to the address's top NODE_W bits, ring_req_addr set to the request address, and ring_req_bytes=64.
- R4: A fill_valid pulse during an outstanding miss installs the line. One cycle later the block gives lrsp_valid with lrsp_far=1 and lrsp_hit=0. If the chosen way held a valid line, ring_req_op=2 (rollout) is raised in the same cycle, with the victim's address and home node and ring_req_bytes=16. If the chosen way was empty, no ring request is raised.
- R5: The victim is the lowest-numbered invalid way of the set. If the set is full, the tree pseudo-LRU picks the way. Its root selects ways 0-1 or ways 2-3, and each access or fill points the tree away from the way it used. After reset every tree points at way 0.
- R6: A write hit or a write miss marks the line dirty. A rollout reports that flag on ring_req_dirty, and a clean valid victim is rolled out with ring_req_dirty=0.
- R7: From a miss's acceptance until its fill completes, lreq_ready is low. It is high again in the cycle the fill response appears.
- R8: A remote read (rmt_op=0) or write (rmt_op=1) gives mem_valid one cycle later, with the same mem_op, the same mem_addr and mem_bytes=64.
- R9: A remote tag update (rmt_op=2) to a local address gives mem_valid with mem_op=2 and mem_bytes=16. A tag update to a far address gives no memory output, and it invalidates a matching cached line, so that the next access to that line misses.
- R10: A remote tag update that names the line of the outstanding miss takes effect when the fill completes. The installed line is left invalid, and the next access to it misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lreq_valid | input | 1 | Local request present |
| lreq_write | input | 1 | Local request is a write |
| lreq_addr | input | AW | Local line address |
| lreq_ready | output | 1 | Local request accepted this cycle (no miss outstanding) |
| lrsp_valid | output | 1 | Local completion |
| lrsp_far | output | 1 | Completion was for a far address |
| lrsp_hit | output | 1 | Far completion was a cache hit |
| ring_req_valid | output | 1 | Outgoing ring request |
| ring_req_op | output | 2 | 1 line read, 2 rollout |
| ring_req_node | output | NODE_W | Destination home node |
| ring_req_addr | output | AW | Line address |
| ring_req_bytes | output | 7 | Transfer size in bytes |
| ring_req_dirty | output | 1 | Rollout victim was dirty |
| fill_valid | input | 1 | Response for the outstanding miss |
| rmt_valid | input | 1 | Incoming remote request |
| rmt_op | input | 2 | 0 read, 1 write, 2 tag update |
| rmt_addr | input | AW | Remote request line address |
| mem_valid | output | 1 | Request to local memory |
| mem_op | output | 2 | Memory operation, same codes as rmt_op |
| mem_addr | output | AW | Memory line address |
| mem_bytes | output | 7 | Transfer size in bytes |

## Verification
A corrupted tag or valid bit shows up as a wrong hit or miss on the very next access to that line. A corrupted pseudo-LRU tree or dirty bit stays hidden until the next fill in that set, where it appears as the wrong rollout address or dirty flag. The bench therefore fills a set, reorders it with hits, and forces several evictions, each with a known victim. It also checks that a deferred or a normal invalidation shows up as a miss on the next access, and that a fill into an empty way raises no rollout.

// File: rtl/fmc_pkg.sv
package fmc_pkg;

    localparam int WAYS   = 4;
    localparam int WAY_W  = 2;
    localparam int TREE_W = 3;

    localparam logic [1:0] RING_READ    = 2'd1;
    localparam logic [1:0] RING_ROLLOUT = 2'd2;

    localparam logic [1:0] RMT_READ  = 2'd0;
    localparam logic [1:0] RMT_WRITE = 2'd1;
    localparam logic [1:0] RMT_TAG   = 2'd2;

    localparam logic [6:0] LINE_BYTES = 7'd64;
    localparam logic [6:0] TAG_BYTES  = 7'd16;

    typedef enum logic {S_IDLE, S_WAIT} fsm_e;

    typedef struct packed {
        logic             found;
        logic [WAY_W-1:0] way;
    } way_pick_t;

    // tree: bit0 root (0 = left pair), bit1 left leaf, bit2 right leaf
    function automatic logic [WAY_W-1:0] tree_pick(input logic [TREE_W-1:0] t);
        return t[0] ? {1'b1, t[2]} : {1'b0, t[1]};
    endfunction

    function automatic logic [TREE_W-1:0] tree_touch(input logic [TREE_W-1:0] t,
                                                     input logic [WAY_W-1:0]  w);
        logic [TREE_W-1:0] n;
        n = t;
        if (!w[1]) begin
            n[0] = 1'b1;
            n[1] = ~w[0];
        end else begin
            n[0] = 1'b0;
            n[2] = ~w[0];
        end
        return n;
    endfunction

    function automatic way_pick_t lowest_free(input logic [WAYS-1:0] v);
        way_pick_t p;
        p = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!v[i]) begin
                p.found = 1'b1;
                p.way   = WAY_W'(i);
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/fmc_tag_store.sv
module fmc_tag_store
    import fmc_pkg::*;
#(
    parameter int SET_W = 2,
    parameter int TAG_W = 14
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [SET_W-1:0]             a_set,
    input  logic [TAG_W-1:0]             a_tag,
    output logic                         a_hit,
    output logic [WAY_W-1:0]             a_way,
    output logic [WAYS-1:0]              a_valid,
    output logic [WAYS-1:0]              a_dirty,
    output logic [WAYS-1:0][TAG_W-1:0]   a_tags,
    input  logic [SET_W-1:0]             b_set,
    input  logic [TAG_W-1:0]             b_tag,
    output logic                         b_hit,
    output logic [WAY_W-1:0]             b_way,
    input  logic                         wr_en,
    input  logic [WAY_W-1:0]             wr_way,
    input  logic [TAG_W-1:0]             wr_tag,
    input  logic                         wr_valid,
    input  logic                         wr_dirty,
    input  logic                         mark_en,
    input  logic [WAY_W-1:0]             mark_way,
    input  logic                         inv_en,
    input  logic [WAY_W-1:0]             inv_way
);
    localparam int SETS = 1 << SET_W;

    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [WAYS-1:0]  val_q [SETS];
    logic [WAYS-1:0]  drt_q [SETS];
    logic [WAYS-1:0]  a_match, b_match;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign a_tags[w]  = tag_q[a_set][w];
        assign a_match[w] = val_q[a_set][w] && (tag_q[a_set][w] == a_tag);
        assign b_match[w] = val_q[b_set][w] && (tag_q[b_set][w] == b_tag);
    end

    assign a_valid = val_q[a_set];
    assign a_dirty = drt_q[a_set];
    assign a_hit   = |a_match;
    assign b_hit   = |b_match;

    always_comb begin
        a_way = '0;
        b_way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (a_match[i]) a_way = WAY_W'(i);
            if (b_match[i]) b_way = WAY_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                val_q[s] <= '0;
                drt_q[s] <= '0;
            end
        end else begin
            if (mark_en) drt_q[a_set][mark_way] <= 1'b1;
            if (wr_en) begin
                tag_q[a_set][wr_way] <= wr_tag;
                val_q[a_set][wr_way] <= wr_valid;
                drt_q[a_set][wr_way] <= wr_dirty;
            end
            if (inv_en && !(wr_en && (b_set == a_set) && (inv_way == wr_way)))
                val_q[b_set][inv_way] <= 1'b0;
        end
    end

endmodule

// File: rtl/fmc_victim.sv
module fmc_victim
    import fmc_pkg::*;
#(
    parameter int SET_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [WAYS-1:0]   valid_vec,
    output logic [WAY_W-1:0]  vic_way,
    output logic              vic_valid,
    input  logic              touch_en,
    input  logic [SET_W-1:0]  touch_set,
    input  logic [WAY_W-1:0]  touch_way
);
    localparam int SETS = 1 << SET_W;

    logic [TREE_W-1:0] tree_q [SETS];
    way_pick_t         free_pick;

    always_comb begin
        free_pick = lowest_free(valid_vec);
        vic_valid = !free_pick.found;
        vic_way   = free_pick.found ? free_pick.way : tree_pick(tree_q[rd_set]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
        end else if (touch_en) begin
            tree_q[touch_set] <= tree_touch(tree_q[touch_set], touch_way);
        end
    end

endmodule

// File: rtl/fmc_ctrl.sv
module fmc_ctrl
    import fmc_pkg::*;
#(
    parameter int AW      = 16,
    parameter int NODE_W  = 2,
    parameter int SET_W   = 2,
    parameter int MY_NODE = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lreq_valid,
    input  logic              lreq_write,
    input  logic [AW-1:0]     lreq_addr,
    output logic              lreq_ready,
    output logic              lrsp_valid,
    output logic              lrsp_far,
    output logic              lrsp_hit,
    output logic              ring_req_valid,
    output logic [1:0]        ring_req_op,
    output logic [NODE_W-1:0] ring_req_node,
    output logic [AW-1:0]     ring_req_addr,
    output logic [6:0]        ring_req_bytes,
    output logic              ring_req_dirty,
    input  logic              fill_valid,
    input  logic              rmt_valid,
    input  logic [1:0]        rmt_op,
    input  logic [AW-1:0]     rmt_addr,
    output logic              mem_valid,
    output logic [1:0]        mem_op,
    output logic [AW-1:0]     mem_addr,
    output logic [6:0]        mem_bytes
);
    localparam int TAG_W = AW - SET_W;
    localparam logic [NODE_W-1:0] SELF = NODE_W'(MY_NODE);

    fsm_e                        state_q;
    logic [AW-1:0]               pend_addr_q;
    logic                        pend_write_q;
    logic                        pend_kill_q;

    logic [AW-1:0]               lk_addr;
    logic                        lreq_far, rmt_far;
    logic                        accept, filling, kill_now, rmt_tag_far;
    logic                        a_hit, b_hit;
    logic [WAY_W-1:0]            a_way, b_way, vic_way;
    logic [WAYS-1:0]             a_valid, a_dirty;
    logic [WAYS-1:0][TAG_W-1:0]  a_tags;
    logic                        vic_valid;
    logic                        touch_en;
    logic [WAY_W-1:0]            touch_way;
    logic [AW-1:0]               vic_addr;

    assign lreq_ready  = (state_q == S_IDLE);
    assign lk_addr     = (state_q == S_WAIT) ? pend_addr_q : lreq_addr;
    assign lreq_far    = (lreq_addr[AW-1 -: NODE_W] != SELF);
    assign rmt_far     = (rmt_addr[AW-1 -: NODE_W] != SELF);
    assign accept      = lreq_valid && lreq_ready;
    assign filling     = (state_q == S_WAIT) && fill_valid;
    assign rmt_tag_far = rmt_valid && (rmt_op == RMT_TAG) && rmt_far;
    assign kill_now    = rmt_tag_far && (state_q == S_WAIT) && (rmt_addr == pend_addr_q);
    assign touch_en    = (accept && lreq_far && a_hit) || filling;
    assign touch_way   = filling ? vic_way : a_way;
    assign vic_addr    = {a_tags[vic_way], lk_addr[SET_W-1:0]};

    fmc_tag_store #(.SET_W(SET_W), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .a_set    (lk_addr[SET_W-1:0]),
        .a_tag    (lk_addr[AW-1:SET_W]),
        .a_hit    (a_hit),
        .a_way    (a_way),
        .a_valid  (a_valid),
        .a_dirty  (a_dirty),
        .a_tags   (a_tags),
        .b_set    (rmt_addr[SET_W-1:0]),
        .b_tag    (rmt_addr[AW-1:SET_W]),
        .b_hit    (b_hit),
        .b_way    (b_way),
        .wr_en    (filling),
        .wr_way   (vic_way),
        .wr_tag   (pend_addr_q[AW-1:SET_W]),
        .wr_valid (!(pend_kill_q || kill_now)),
        .wr_dirty (pend_write_q),
        .mark_en  (accept && lreq_far && a_hit && lreq_write),
        .mark_way (a_way),
        .inv_en   (rmt_tag_far && b_hit),
        .inv_way  (b_way)
    );

    fmc_victim #(.SET_W(SET_W)) u_victim (
        .clk       (clk),
        .rst       (rst),
        .rd_set    (lk_addr[SET_W-1:0]),
        .valid_vec (a_valid),
        .vic_way   (vic_way),
        .vic_valid (vic_valid),
        .touch_en  (touch_en),
        .touch_set (lk_addr[SET_W-1:0]),
        .touch_way (touch_way)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q        <= S_IDLE;
            pend_addr_q    <= '0;
            pend_write_q   <= 1'b0;
            pend_kill_q    <= 1'b0;
            lrsp_valid     <= 1'b0;
            lrsp_far       <= 1'b0;
            lrsp_hit       <= 1'b0;
            ring_req_valid <= 1'b0;
            ring_req_op    <= '0;
            ring_req_node  <= '0;
            ring_req_addr  <= '0;
            ring_req_bytes <= '0;
            ring_req_dirty <= 1'b0;
            mem_valid      <= 1'b0;
            mem_op         <= '0;
            mem_addr       <= '0;
            mem_bytes      <= '0;
        end else begin
            lrsp_valid     <= 1'b0;
            ring_req_valid <= 1'b0;
            mem_valid      <= 1'b0;

            if (accept) begin
                if (!lreq_far) begin
                    lrsp_valid <= 1'b1;
                    lrsp_far   <= 1'b0;
                    lrsp_hit   <= 1'b0;
                end else if (a_hit) begin
                    lrsp_valid <= 1'b1;
                    lrsp_far   <= 1'b1;
                    lrsp_hit   <= 1'b1;
                end else begin
                    ring_req_valid <= 1'b1;
                    ring_req_op    <= RING_READ;
                    ring_req_node  <= lreq_addr[AW-1 -: NODE_W];
                    ring_req_addr  <= lreq_addr;
                    ring_req_bytes <= LINE_BYTES;
                    ring_req_dirty <= 1'b0;
                    pend_addr_q    <= lreq_addr;
                    pend_write_q   <= lreq_write;
                    pend_kill_q    <= 1'b0;
                    state_q        <= S_WAIT;
                end
            end

            if (state_q == S_WAIT) begin
                if (kill_now) pend_kill_q <= 1'b1;
                if (filling) begin
                    lrsp_valid <= 1'b1;
                    lrsp_far   <= 1'b1;
                    lrsp_hit   <= 1'b0;
                    state_q    <= S_IDLE;
                    if (vic_valid) begin
                        ring_req_valid <= 1'b1;
                        ring_req_op    <= RING_ROLLOUT;
                        ring_req_node  <= vic_addr[AW-1 -: NODE_W];
                        ring_req_addr  <= vic_addr;
                        ring_req_bytes <= TAG_BYTES;
                        ring_req_dirty <= a_dirty[vic_way];
                    end
                end
            end

            if (rmt_valid && !((rmt_op == RMT_TAG) && rmt_far)) begin
                mem_valid <= 1'b1;
                mem_op    <= rmt_op;
                mem_addr  <= rmt_addr;
                mem_bytes <= (rmt_op == RMT_TAG) ? TAG_BYTES : LINE_BYTES;
            end
        end
    end

endmodule

// File: rtl/fmc_ctrl_chk.sv
module fmc_ctrl_chk
    import fmc_pkg::*;
#(
    parameter int NODE_W  = 2,
    parameter int MY_NODE = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              lreq_ready,
    input logic              lrsp_valid,
    input logic              lrsp_far,
    input logic              lrsp_hit,
    input logic              ring_req_valid,
    input logic [1:0]        ring_req_op,
    input logic [NODE_W-1:0] ring_req_node,
    input logic [6:0]        ring_req_bytes,
    input logic              mem_valid,
    input logic [1:0]        mem_op,
    input logic [6:0]        mem_bytes
);
    AST_LOCAL_NEVER_HITS: assert property (@(posedge clk) disable iff (rst)
        lrsp_valid && !lrsp_far |-> !lrsp_hit); // R1

    AST_HIT_NO_RING: assert property (@(posedge clk) disable iff (rst)
        lrsp_valid && lrsp_hit |-> !ring_req_valid); // R2

    AST_MISS_TO_REMOTE_HOME: assert property (@(posedge clk) disable iff (rst)
        ring_req_valid && ring_req_op == RING_READ |->
            ring_req_node != NODE_W'(MY_NODE) && ring_req_bytes == LINE_BYTES); // R3

    AST_ROLLOUT_WITH_FILL: assert property (@(posedge clk) disable iff (rst)
        ring_req_valid && ring_req_op == RING_ROLLOUT |->
            lrsp_valid && lrsp_far && !lrsp_hit && ring_req_bytes == TAG_BYTES); // R4

    AST_RING_OP_LEGAL: assert property (@(posedge clk) disable iff (rst)
        ring_req_valid |-> ring_req_op == RING_READ || ring_req_op == RING_ROLLOUT); // R3

    AST_STALL_WHILE_MISS: assert property (@(posedge clk) disable iff (rst)
        ring_req_valid && ring_req_op == RING_READ |-> !lreq_ready); // R7

    AST_FILL_REOPENS: assert property (@(posedge clk) disable iff (rst)
        lrsp_valid && lrsp_far && !lrsp_hit |-> lreq_ready); // R7

    AST_MEM_OP_LEGAL: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> mem_op != 2'd3); // R8

    AST_TAG_UPDATE_SIZE: assert property (@(posedge clk) disable iff (rst)
        mem_valid && mem_op == RMT_TAG |-> mem_bytes == TAG_BYTES); // R9

endmodule

bind fmc_ctrl fmc_ctrl_chk #(.NODE_W(NODE_W), .MY_NODE(MY_NODE)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .lreq_ready     (lreq_ready),
    .lrsp_valid     (lrsp_valid),
    .lrsp_far       (lrsp_far),
    .lrsp_hit       (lrsp_hit),
    .ring_req_valid (ring_req_valid),
    .ring_req_op    (ring_req_op),
    .ring_req_node  (ring_req_node),
    .ring_req_bytes (ring_req_bytes),
    .mem_valid      (mem_valid),
    .mem_op         (mem_op),
    .mem_bytes      (mem_bytes)
);

// File: tb/tb_fmc_ctrl.sv
`timescale 1ns/1ps
module tb_fmc_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lreq_valid = 1'b0, lreq_write = 1'b0;
    logic [15:0] lreq_addr = '0;
    logic        lreq_ready, lrsp_valid, lrsp_far, lrsp_hit;
    logic        ring_req_valid, ring_req_dirty;
    logic [1:0]  ring_req_op;
    logic [1:0]  ring_req_node;
    logic [15:0] ring_req_addr;
    logic [6:0]  ring_req_bytes;
    logic        fill_valid = 1'b0;
    logic        rmt_valid = 1'b0;
    logic [1:0]  rmt_op = '0;
    logic [15:0] rmt_addr = '0;
    logic        mem_valid;
    logic [1:0]  mem_op;
    logic [15:0] mem_addr;
    logic [6:0]  mem_bytes;

    int n_run = 0;
    int n_fail = 0;

    logic [1:0]  lrsp_q[$];
    logic [27:0] ring_q[$];
    logic [24:0] mem_q[$];
    string       lrsp_t[$];
    string       ring_t[$];
    string       mem_t[$];

    always #2 clk = ~clk;

    fmc_ctrl dut (
        .clk(clk), .rst(rst),
        .lreq_valid(lreq_valid), .lreq_write(lreq_write), .lreq_addr(lreq_addr),
        .lreq_ready(lreq_ready), .lrsp_valid(lrsp_valid), .lrsp_far(lrsp_far),
        .lrsp_hit(lrsp_hit), .ring_req_valid(ring_req_valid), .ring_req_op(ring_req_op),
        .ring_req_node(ring_req_node), .ring_req_addr(ring_req_addr),
        .ring_req_bytes(ring_req_bytes), .ring_req_dirty(ring_req_dirty),
        .fill_valid(fill_valid), .rmt_valid(rmt_valid), .rmt_op(rmt_op),
        .rmt_addr(rmt_addr), .mem_valid(mem_valid), .mem_op(mem_op),
        .mem_addr(mem_addr), .mem_bytes(mem_bytes)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] got,
                         input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // monitor: compares every produced output against the scoreboard queues
    always @(negedge clk) begin
        if (!rst) begin
            if (lrsp_valid) begin
                if (lrsp_q.size() == 0) check(0, "unexpected lrsp", {lrsp_far, lrsp_hit}, 0);
                else begin
                    logic [1:0] e; string t;
                    e = lrsp_q.pop_front(); t = lrsp_t.pop_front();
                    check({lrsp_far, lrsp_hit} == e, t, {lrsp_far, lrsp_hit}, e);
                end
            end
            if (ring_req_valid) begin
                logic [27:0] g;
                g = {ring_req_op, ring_req_node, ring_req_addr, ring_req_bytes, ring_req_dirty};
                if (ring_q.size() == 0) check(0, "unexpected ring request", g, 0);
                else begin
                    logic [27:0] e; string t;
                    e = ring_q.pop_front(); t = ring_t.pop_front();
                    check(g == e, t, g, e);
                end
            end
            if (mem_valid) begin
                logic [24:0] g;
                g = {mem_op, mem_addr, mem_bytes};
                if (mem_q.size() == 0) check(0, "unexpected mem request", g, 0);
                else begin
                    logic [24:0] e; string t;
                    e = mem_q.pop_front(); t = mem_t.pop_front();
                    check(g == e, t, g, e);
                end
            end
        end
    end

    task automatic drained(input string tag);
        check(lrsp_q.size() == 0 && ring_q.size() == 0 && mem_q.size() == 0,
              {tag, " expected outputs produced"},
              32'(lrsp_q.size() + ring_q.size() + mem_q.size()), 0);
    endtask

    task automatic push_ring(input logic [1:0] op, input logic [15:0] a,
                             input logic [6:0] b, input logic d, input string t);
        ring_q.push_back({op, a[15:14], a, b, d});
        ring_t.push_back(t);
    endtask

    task automatic local_req(input logic [15:0] a, input logic w);
        @(negedge clk);
        lreq_valid = 1'b1; lreq_addr = a; lreq_write = w;
        @(negedge clk);
        lreq_valid = 1'b0; lreq_write = 1'b0;
    endtask

    task automatic do_access(input logic [15:0] a, input logic w, input logic far,
                             input logic hit, input string t);
        lrsp_q.push_back({far, hit}); lrsp_t.push_back(t);
        local_req(a, w);
        @(negedge clk);
        drained(t);
    endtask

    task automatic do_miss(input logic [15:0] a, input logic w, input logic roll,
                           input logic [15:0] va, input logic vd, input logic kill,
                           input string t);
        push_ring(2'd1, a, 7'd64, 1'b0, {t, " R3 miss read"});
        local_req(a, w);
        check(lreq_ready == 1'b0, "R7 ready low after miss", lreq_ready, 0);
        if (kill) begin
            rmt_valid = 1'b1; rmt_op = 2'd2; rmt_addr = a;
            @(negedge clk);
            rmt_valid = 1'b0;
        end
        repeat (2) @(negedge clk);
        check(lreq_ready == 1'b0, "R7 ready low while waiting", lreq_ready, 0);
        lrsp_q.push_back(2'b10); lrsp_t.push_back({t, " R4 fill response"});
        if (roll) push_ring(2'd2, va, 7'd16, vd, {t, " R4/R5/R6 rollout"});
        fill_valid = 1'b1;
        @(negedge clk);
        fill_valid = 1'b0;
        check(lreq_ready == 1'b1, "R7 ready high after fill", lreq_ready, 1);
        @(negedge clk);
        drained(t);
    endtask

    task automatic do_rmt(input logic [1:0] op, input logic [15:0] a, input logic exp_mem,
                          input logic [6:0] b, input string t);
        if (exp_mem) begin
            mem_q.push_back({op, a, b}); mem_t.push_back(t);
        end
        @(negedge clk);
        rmt_valid = 1'b1; rmt_op = op; rmt_addr = a;
        @(negedge clk);
        rmt_valid = 1'b0;
        if (!exp_mem) check(mem_valid == 1'b0, {t, " no mem output"}, mem_valid, 0);
        @(negedge clk);
        drained(t);
    endtask

    function automatic logic [15:0] fa(input int t);
        return 16'h4000 | 16'(t << 2);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(lreq_ready == 1'b1, "reset ready", lreq_ready, 1);
        check(!lrsp_valid && !ring_req_valid && !mem_valid, "reset outputs idle",
              {lrsp_valid, ring_req_valid, mem_valid}, 0);

        do_access(16'h0010, 1'b0, 1'b0, 1'b0, "R1 local read");
        do_access(16'h0031, 1'b1, 1'b0, 1'b0, "R1 local write");

        do_miss(fa(0), 1'b0, 1'b0, '0, 1'b0, 1'b0, "R4 empty way A0");
        do_access(fa(0), 1'b0, 1'b1, 1'b1, "R2 hit A0");
        do_miss(fa(1), 1'b1, 1'b0, '0, 1'b0, 1'b0, "R6 write miss A1");
        do_miss(fa(2), 1'b0, 1'b0, '0, 1'b0, 1'b0, "R5 fill A2");
        do_miss(fa(3), 1'b0, 1'b0, '0, 1'b0, 1'b0, "R5 fill A3");
        do_access(fa(0), 1'b0, 1'b1, 1'b1, "R2 hit A0 again");
        do_miss(fa(4), 1'b0, 1'b1, fa(2), 1'b0, 1'b0, "R5 R6 evict clean A2");
        do_miss(fa(5), 1'b0, 1'b1, fa(1), 1'b1, 1'b0, "R5 R6 evict dirty A1");
        do_access(fa(4), 1'b1, 1'b1, 1'b1, "R6 write hit A4");

        do_rmt(2'd2, fa(3), 1'b0, 7'd16, "R9 far tag update A3");
        do_miss(fa(3), 1'b0, 1'b0, '0, 1'b0, 1'b0, "R9 A3 misses after invalidate");
        do_miss(fa(6), 1'b0, 1'b1, fa(0), 1'b0, 1'b0, "R5 evict A0");
        do_miss(fa(7), 1'b0, 1'b1, fa(4), 1'b1, 1'b0, "R6 evict write-hit A4");

        do_rmt(2'd0, 16'h0123, 1'b1, 7'd64, "R8 remote read");
        do_rmt(2'd1, 16'h0222, 1'b1, 7'd64, "R8 remote write");
        do_rmt(2'd2, 16'h0345, 1'b1, 7'd16, "R9 local tag update");

        do_miss(16'h4001, 1'b0, 1'b0, '0, 1'b0, 1'b1, "R10 tag update during fill");
        do_miss(16'h4001, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R10 line left invalid");

        do_miss(16'hC002, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R3 node 3 home");
        do_access(16'hC002, 1'b0, 1'b1, 1'b1, "R2 hit node 3 line");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule